// File: doc/BRIEF.md
# Two-Wire Serial Master, Write-Only

This block is the transmit side of a two-wire serial bus master. The host hands it a 7-bit target address and then pushes data bytes through a one-byte holding register. The first byte accepted while the bus is free opens a transfer. The master sends a START condition, then the address with a write direction bit, and then each data byte. After every byte it releases the data line for one clock so that the target can acknowledge.

The host paces the transfer. When a byte has been acknowledged and no new byte is waiting, the master keeps the clock line low. It holds it there until the host supplies another byte or asks for a STOP. If the target does not acknowledge a byte, the master records a sticky flag, discards any waiting byte and closes the bus with a STOP on its own.

The bus pins are open-drain style: the block only says when to pull each line low. SCL high and SCL low phases each last `HALF_CYC` system clocks.

Top module: `i2cw_master`

## Requirements
- R1: After reset, both bus lines are released, the master is disabled, `txh_ready` is 0, and `flag_tx_free`, `flag_nack` and `irq` are 0.
- R2: The byte input is valid/ready. A byte is taken in a cycle where `txh_valid` and `txh_ready` are both 1. `txh_ready` is 1 only while the master is enabled, the holding register is empty and `flag_nack` is 0. The host may hold `txh_valid` high for any number of cycles.
- R3: A byte accepted while the bus is free starts a transfer. The master pulls SDA low while SCL is high (START). It then sends the 7 address bits MSB first, followed by a direction bit of 0.
- R4: Every byte is sent MSB first. SDA changes only while SCL is low, except for START and STOP. Each SCL high phase of a bit lasts exactly `HALF_CYC` clocks.
- R5: On the ninth clock of each byte, the master releases SDA and samples it at the middle of the SCL high phase. A low level is an acknowledge. It sets `flag_tx_free` and moves a waiting byte into the shifter, so that byte follows at once.
- R6: After an acknowledge, if no byte is waiting and no STOP is pending, SCL is held low with no further clock pulses for as long as that lasts.
- R7: A `cmd_stop` pulse during a transfer makes the master emit a STOP (SDA rising while SCL is high) and then release both lines. This happens once the current byte and any waiting byte have been acknowledged. A `cmd_stop` pulse while the bus is free has no effect.
- R8: A missing acknowledge sets `flag_nack`, discards the waiting byte, leaves `flag_tx_free` unchanged and emits a STOP. No further byte is sent.
- R9: `flag_nack` stays 1 until a `sts_rd` pulse clears it. While it is 1, no byte is accepted.
- R10: `flag_tx_free` stays 1 until the next accepted byte. A `cmd_disable` pulse clears it and stops byte intake. A later `cmd_enable` pulse restores intake but leaves the flag at 0.
- R11: `irq` is 1 exactly when (`flag_tx_free` and `ie_tx_free`) or (`flag_nack` and `ie_nack`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Target address sent after START |
| txh_data | input | 8 | Byte offered to the holding register |
| txh_valid | input | 1 | Byte offer is valid |
| txh_ready | output | 1 | Holding register can take a byte |
| cmd_stop | input | 1 | Request a STOP (one-cycle pulse) |
| cmd_enable | input | 1 | Enable the master (pulse) |
| cmd_disable | input | 1 | Disable the master and clear the free flag (pulse) |
| sts_rd | input | 1 | Status read strobe, clears the NACK flag |
| ie_tx_free | input | 1 | Interrupt enable for the free flag |
| ie_nack | input | 1 | Interrupt enable for the NACK flag |
| flag_tx_free | output | 1 | Acknowledge seen, no byte written since |
| flag_nack | output | 1 | Sticky missing-acknowledge flag |
| irq | output | 1 | Interrupt request |
| scl_drv_low | output | 1 | Pull SCL low when 1 |
| sda_drv_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
A bus-level target model decodes START, bytes and STOP from the wired lines and answers each ninth clock with an acknowledge, or withholds it on a chosen byte. Four input patterns are compared against a queue of expected bus items.

- A single byte left without a follow-up shows whether the clock is stretched or runs on.
- Three bytes pushed back to back with a STOP requested early show whether waiting data wins over the pending STOP.
- A refused data byte with another byte already waiting shows whether that byte is truly dropped.
- A refused address shows that the data byte never reaches the bus.

A STOP pulse on a free bus and a disable/enable pair check that neither disturbs the lines or revives the free flag.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_STOP_LOW,
    ST_STOP_HIGH,
    ST_STOP_FREE
  } eng_st_t;
endpackage

// File: rtl/i2cw_phase_timer.sv
module i2cw_phase_timer #(
  parameter int unsigned HALF_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_clr,
  output logic ph_mid,
  output logic ph_done
);
  localparam int unsigned CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LASTV = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] MIDV  = CW'(HALF_CYC / 2 - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (hold_clr || cnt == LASTV) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign ph_done = !hold_clr && (cnt == LASTV);
  assign ph_mid  = !hold_clr && (cnt == MIDV);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= LASTV));
endmodule

// File: rtl/i2cw_hostif.sv
module i2cw_hostif #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] txh_data,
  input  logic          txh_valid,
  output logic          txh_ready,
  input  logic          cmd_stop,
  input  logic          cmd_enable,
  input  logic          cmd_disable,
  input  logic          sts_rd,
  input  logic          ie_tx_free,
  input  logic          ie_nack,
  input  logic          eng_load,
  input  logic          eng_ack,
  input  logic          eng_nack,
  input  logic          eng_open,
  input  logic          eng_stop_taken,
  output logic          hold_full,
  output logic [DW-1:0] hold_data,
  output logic          stop_req,
  output logic          tx_free,
  output logic          nack,
  output logic          irq
);
  logic enabled;
  logic wr_acc;

  assign txh_ready = enabled && !hold_full && !nack;
  assign wr_acc    = txh_valid && txh_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled   <= 1'b0;
      hold_full <= 1'b0;
      hold_data <= '0;
      tx_free   <= 1'b0;
      nack      <= 1'b0;
      stop_req  <= 1'b0;
    end else begin
      if (cmd_disable)     enabled <= 1'b0;
      else if (cmd_enable) enabled <= 1'b1;

      if (eng_nack || eng_load) hold_full <= 1'b0;
      else if (wr_acc)          hold_full <= 1'b1;
      if (wr_acc) hold_data <= txh_data;

      if (cmd_disable)  tx_free <= 1'b0;
      else if (wr_acc)  tx_free <= 1'b0;
      else if (eng_ack) tx_free <= 1'b1;

      if (eng_nack)    nack <= 1'b1;
      else if (sts_rd) nack <= 1'b0;

      if (eng_stop_taken)            stop_req <= 1'b0;
      else if (cmd_stop && eng_open) stop_req <= 1'b1;
    end
  end

  assign irq = (tx_free && ie_tx_free) || (nack && ie_nack);

  // R5
  ack_sets_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_ack && !cmd_disable && !wr_acc) |=> tx_free);
  // R9
  nack_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nack && !sts_rd) |=> nack);
  // R8
  nack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_nack |=> (!hold_full && nack));
  // R10
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_disable |=> (!tx_free && !txh_ready));
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
  import i2cw_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph_mid,
  input  logic          ph_done,
  input  logic [DW-2:0] dev_addr,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  logic          stop_req,
  input  logic          sda_in,
  output logic          scl_low,
  output logic          sda_low,
  output logic          ph_clr,
  output logic          load,
  output logic          ack_evt,
  output logic          nack_evt,
  output logic          open_xfer,
  output logic          stop_taken
);
  localparam int unsigned BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] ACK_SLOT = BCW'(DW);

  eng_st_t        st;
  logic [DW-1:0]  sh;
  logic [BCW-1:0] bitn;
  logic           ack_smp;
  logic           last;
  logic           byte_end;

  always_comb begin
    last       = (bitn == ACK_SLOT);
    byte_end   = (st == ST_HIGH) && ph_done && last;
    ack_evt    = byte_end && !ack_smp;
    nack_evt   = byte_end && ack_smp;
    load       = (ack_evt && hold_full) || ((st == ST_HOLD) && hold_full);
    stop_taken = nack_evt
              || (ack_evt && !hold_full && stop_req)
              || ((st == ST_HOLD) && !hold_full && stop_req);
    ph_clr     = (st == ST_IDLE) || (st == ST_HOLD);
    open_xfer  = (st == ST_START) || (st == ST_LOW) || (st == ST_HIGH) || (st == ST_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sh      <= '0;
      bitn    <= '0;
      ack_smp <= 1'b1;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (hold_full) begin
            st      <= ST_START;
            sda_low <= 1'b1;
            sh      <= {dev_addr, 1'b0};
            bitn    <= '0;
          end
        end
        ST_START: begin
          if (ph_done) begin
            st      <= ST_LOW;
            scl_low <= 1'b1;
          end
        end
        ST_LOW: begin
          if (ph_mid) sda_low <= last ? 1'b0 : !sh[DW-1];
          if (ph_done) begin
            st      <= ST_HIGH;
            scl_low <= 1'b0;
          end
        end
        ST_HIGH: begin
          if (ph_mid && last) ack_smp <= sda_in;
          if (ph_done) begin
            scl_low <= 1'b1;
            if (!last) begin
              sh   <= {sh[DW-2:0], 1'b0};
              bitn <= bitn + 1'b1;
              st   <= ST_LOW;
            end else if (nack_evt) begin
              st <= ST_STOP_LOW;
            end else if (hold_full) begin
              sh   <= hold_data;
              bitn <= '0;
              st   <= ST_LOW;
            end else if (stop_req) begin
              st <= ST_STOP_LOW;
            end else begin
              st <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (hold_full) begin
            sh   <= hold_data;
            bitn <= '0;
            st   <= ST_LOW;
          end else if (stop_req) begin
            st <= ST_STOP_LOW;
          end
        end
        ST_STOP_LOW: begin
          if (ph_mid) sda_low <= 1'b1;
          if (ph_done) begin
            st      <= ST_STOP_HIGH;
            scl_low <= 1'b0;
          end
        end
        ST_STOP_HIGH: begin
          if (ph_done) begin
            sda_low <= 1'b0;
            st      <= ST_STOP_FREE;
          end
        end
        ST_STOP_FREE: begin
          if (ph_done) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  start_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START) |-> (!scl_low && sda_low));
  // R4
  sda_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && !$past(scl_low) && (sda_low != $past(sda_low)))
      |-> ((st == ST_START) || (st == ST_STOP_FREE)));
  // R6
  stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> (scl_low && !sda_low));
  // R8
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> ((st == ST_STOP_LOW) && scl_low));
  // R7
  stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_taken |=> (st == ST_STOP_LOW));
endmodule

// File: rtl/i2cw_master.sv
module i2cw_master #(
  parameter int unsigned HALF_CYC = 8,
  parameter int unsigned DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-2:0] dev_addr,
  input  logic [DW-1:0] txh_data,
  input  logic          txh_valid,
  output logic          txh_ready,
  input  logic          cmd_stop,
  input  logic          cmd_enable,
  input  logic          cmd_disable,
  input  logic          sts_rd,
  input  logic          ie_tx_free,
  input  logic          ie_nack,
  output logic          flag_tx_free,
  output logic          flag_nack,
  output logic          irq,
  output logic          scl_drv_low,
  output logic          sda_drv_low,
  input  logic          sda_in
);
  logic          ph_mid, ph_done, ph_clr;
  logic          load, ack_evt, nack_evt, open_xfer, stop_taken;
  logic          hold_full, stop_req;
  logic [DW-1:0] hold_data;

  i2cw_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold_clr(ph_clr),
    .ph_mid(ph_mid), .ph_done(ph_done)
  );

  i2cw_hostif #(.DW(DW)) u_host (
    .clk(clk), .rst_n(rst_n),
    .txh_data(txh_data), .txh_valid(txh_valid), .txh_ready(txh_ready),
    .cmd_stop(cmd_stop), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .sts_rd(sts_rd), .ie_tx_free(ie_tx_free), .ie_nack(ie_nack),
    .eng_load(load), .eng_ack(ack_evt), .eng_nack(nack_evt),
    .eng_open(open_xfer), .eng_stop_taken(stop_taken),
    .hold_full(hold_full), .hold_data(hold_data), .stop_req(stop_req),
    .tx_free(flag_tx_free), .nack(flag_nack), .irq(irq)
  );

  i2cw_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .ph_mid(ph_mid), .ph_done(ph_done),
    .dev_addr(dev_addr), .hold_full(hold_full), .hold_data(hold_data),
    .stop_req(stop_req), .sda_in(sda_in),
    .scl_low(scl_drv_low), .sda_low(sda_drv_low), .ph_clr(ph_clr),
    .load(load), .ack_evt(ack_evt), .nack_evt(nack_evt),
    .open_xfer(open_xfer), .stop_taken(stop_taken)
  );
endmodule

// File: tb/i2cw_master_tb.sv
module i2cw_master_tb;
  localparam int HALF = 8;
  localparam int TOK_START = 256;
  localparam int TOK_STOP  = 257;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [6:0] dev_addr = 7'h5A;
  logic [7:0] txh_data = 8'h00;
  logic       txh_valid = 1'b0, cmd_stop = 1'b0, cmd_enable = 1'b0, cmd_disable = 1'b0;
  logic       sts_rd = 1'b0, ie_tx_free = 1'b0, ie_nack = 1'b0;
  logic       slv_pull = 1'b0;
  wire        txh_ready, flag_tx_free, flag_nack, irq, scl_drv_low, sda_drv_low;
  wire        scl_line = ~scl_drv_low;
  wire        sda_line = ~(sda_drv_low | slv_pull);

  i2cw_master #(.HALF_CYC(HALF), .DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
    .txh_data(txh_data), .txh_valid(txh_valid), .txh_ready(txh_ready),
    .cmd_stop(cmd_stop), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .sts_rd(sts_rd), .ie_tx_free(ie_tx_free), .ie_nack(ie_nack),
    .flag_tx_free(flag_tx_free), .flag_nack(flag_nack), .irq(irq),
    .scl_drv_low(scl_drv_low), .sda_drv_low(sda_drv_low), .sda_in(sda_line)
  );

  int exp_q[$];
  int n_cmp = 0, n_bad = 0;
  int nack_byte = -1;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] shv = 8'h00;
  int nr = 0, byte_idx = 0, hcnt = 0, n_hi = 0, bad_hi = 0, rises = 0;
  logic hi_valid = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic observe(input int tok);
    if (exp_q.size() == 0) check(1'b0, "R3 unexpected bus item", tok, -1);
    else begin
      int e;
      e = exp_q.pop_front();
      check(tok == e, "R4 bus item order", tok, e);
    end
  endtask

  // monitor and target model
  always @(negedge clk) begin
    if (rst_n) begin
      if (!p_scl && scl_line) begin hcnt = 1; hi_valid = 1'b1; end
      else if (scl_line) hcnt++;
      if (p_scl && scl_line && p_sda && !sda_line) begin
        observe(TOK_START); nr = 0; byte_idx = 0; hi_valid = 1'b0;
      end else if (p_scl && scl_line && !p_sda && sda_line) begin
        observe(TOK_STOP); nr = 0;
      end
      if (!p_scl && scl_line) begin
        rises++;
        if (nr < 8) shv = {shv[6:0], sda_line};
        nr++;
        if (nr == 8) observe(int'(shv));
      end
      if (p_scl && !scl_line) begin
        if (hi_valid) begin n_hi++; if (hcnt != HALF) bad_hi++; end
        hi_valid = 1'b0;
        if (nr == 8) slv_pull = (byte_idx != nack_byte);
        else if (nr == 9) begin slv_pull = 1'b0; nr = 0; byte_idx++; end
      end
      p_scl = scl_line;
      p_sda = sda_line;
    end
  end

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cmd_stop = 1'b1;
      1: cmd_enable = 1'b1;
      2: cmd_disable = 1'b1;
      default: sts_rd = 1'b1;
    endcase
    @(negedge clk);
    cmd_stop = 1'b0; cmd_enable = 1'b0; cmd_disable = 1'b0; sts_rd = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b);
    int w = 0;
    @(negedge clk);
    while (!txh_ready && w < 3000) begin @(negedge clk); w++; end
    txh_data = b; txh_valid = 1'b1;
    @(negedge clk);
    txh_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    int w = 0;
    while (exp_q.size() != 0 && w < 5000) begin @(negedge clk); w++; end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(scl_line && sda_line, "R1 lines released", {scl_line, sda_line}, 3);
    check(!txh_ready && !flag_tx_free && !flag_nack && !irq, "R1 flags clear",
          {txh_ready, flag_tx_free, flag_nack, irq}, 0);

    pulse(1);
    check(txh_ready == 1'b1, "R2 ready after enable", txh_ready, 1);

    // R7 stop on a free bus: no effect
    pulse(0);
    repeat (100) @(negedge clk);
    check(scl_line && sda_line, "R7 idle stop ignored", {scl_line, sda_line}, 3);

    // single byte, then stretch
    ie_tx_free = 1'b1;
    exp_q.push_back(TOK_START); exp_q.push_back(8'hB4); exp_q.push_back(8'hC3);
    write_byte(8'hC3);
    check(txh_ready == 1'b0, "R2 ready drops while byte held", txh_ready, 0);
    drain("R3 address and byte sent");
    repeat (4 * HALF) @(negedge clk);
    r = rises;
    repeat (300) @(negedge clk);
    check(rises == r, "R6 no clock pulses while stretched", rises - r, 0);
    check(scl_line == 1'b0, "R6 SCL held low", scl_line, 0);
    check(flag_tx_free == 1'b1, "R5 free flag after ack", flag_tx_free, 1);
    check(irq == 1'b1, "R11 irq from free flag", irq, 1);
    exp_q.push_back(TOK_STOP);
    pulse(0);
    drain("R7 stop emitted");
    repeat (3 * HALF) @(negedge clk);
    check(scl_line && sda_line, "R7 bus released after stop", {scl_line, sda_line}, 3);

    // three bytes back to back, stop requested early
    exp_q.push_back(TOK_START); exp_q.push_back(8'hB4);
    exp_q.push_back(8'h11); exp_q.push_back(8'h22); exp_q.push_back(8'h33);
    exp_q.push_back(TOK_STOP);
    write_byte(8'h11);
    write_byte(8'h22);
    write_byte(8'h33);
    pulse(0);
    drain("R7 waiting bytes go before stop");
    repeat (3 * HALF) @(negedge clk);
    check(flag_tx_free == 1'b1, "R5 free flag after last ack", flag_tx_free, 1);
    check(bad_hi == 0 && n_hi > 0, "R4 SCL high phase length", bad_hi, 0);

    // R10 disable then enable
    pulse(2);
    check(!flag_tx_free && !txh_ready, "R10 disable clears flag and intake",
          {flag_tx_free, txh_ready}, 0);
    pulse(1);
    check(!flag_tx_free && txh_ready, "R10 enable keeps flag clear",
          {flag_tx_free, txh_ready}, 1);
    check(irq == 1'b0, "R11 irq low with flags clear", irq, 0);

    // data byte refused with a byte waiting
    ie_tx_free = 1'b0; ie_nack = 1'b1; nack_byte = 1;
    exp_q.push_back(TOK_START); exp_q.push_back(8'hB4); exp_q.push_back(8'h96);
    exp_q.push_back(TOK_STOP);
    write_byte(8'h96);
    begin
      int w = 0;
      while (!flag_tx_free && w < 3000) begin @(negedge clk); w++; end
    end
    write_byte(8'h77);
    drain("R8 stop after refused byte");
    repeat (3 * HALF) @(negedge clk);
    check(flag_nack == 1'b1, "R8 nack flag set", flag_nack, 1);
    check(flag_tx_free == 1'b0, "R8 free flag not set by nack", flag_tx_free, 0);
    check(irq == 1'b1, "R11 irq from nack flag", irq, 1);
    check(txh_ready == 1'b0, "R9 intake blocked by nack", txh_ready, 0);
    repeat (400) @(negedge clk);
    check(scl_line && sda_line, "R8 waiting byte dropped", {scl_line, sda_line}, 3);
    check(flag_nack == 1'b1, "R9 nack flag sticky", flag_nack, 1);
    pulse(3);
    check(!flag_nack && txh_ready && !irq, "R9 status read clears nack",
          {flag_nack, txh_ready, irq}, 2);

    // address refused
    nack_byte = 0; dev_addr = 7'h21;
    exp_q.push_back(TOK_START); exp_q.push_back(8'h42); exp_q.push_back(TOK_STOP);
    write_byte(8'hEE);
    drain("R8 stop after refused address");
    repeat (400) @(negedge clk);
    check(flag_nack == 1'b1, "R8 nack on address", flag_nack, 1);
    check(scl_line && sda_line, "R8 data byte never sent", {scl_line, sda_line}, 3);
    pulse(3);
    nack_byte = -1;
    check(flag_nack == 1'b0, "R9 nack cleared again", flag_nack, 0);

    summary();
    $finish;
  end
endmodule